// File: doc/BRIEF.md
# Stateful Implication Cell Array

This block keeps a small array of single-bit cells and applies to them a stream of stateful-logic micro-operations, at most one per clock. It has two kinds of micro-operation. The first is a clear, which forces one chosen cell to 0. The second is an implication step. It reads a source cell and a target cell, then writes (NOT source) OR target back into the target. The source cell is not changed.

Any Boolean function can be built from these two primitives by running a sequence of them. Software or a sequencer sets up the input cells through a load port. It clears the work and result cells, then issues the steps one after another. The result is read back through a registered read port.

A logic 1 in a cell stands for the low-resistance state of a resistive element, and a 0 stands for the high-resistance state. Only the logical value is modelled.

Top module: `imply_array_top`

## Requirements
- R1: With `uop_valid` high and `uop_code` = 1 (implication), the target cell becomes (NOT source) OR target. From (source, target) the results are 00→1, 01→1, 10→0 and 11→1.
- R2: An implication step leaves the source cell unchanged when the source and target indices differ.
- R3: With `uop_valid` high and `uop_code` = 0 (clear), the target cell becomes 0 whatever it held before.
- R4: An implication step whose source index equals its target index sets that cell to 1.
- R5: With `ld_en` high, cell `ld_idx` takes `ld_bit` at the clock edge. If the same edge also carries a micro-operation on that cell, the load wins.
- R6: `clash` is high for exactly one cycle after an edge where `ld_en` and `uop_valid` were both high and `ld_idx` equalled `uop_dst`, and low otherwise. A load and a micro-operation on different cells both take effect.
- R7: `rd_bit` is registered. After an edge it shows the value cell `rd_idx` held before that edge, so a write on that same edge appears one cycle later.
- R8: A synchronous active-high `rst` clears every cell, `rd_bit` and `clash` to 0.
- R9: When neither `uop_valid` nor `ld_en` is high, no cell changes.
- R10: Back-to-back micro-operations each see the results of the ones before them. For example, clear r, then p→r, then q→r leaves NAND(p,q) in r.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load strobe |
| ld_idx | input | 4 | Cell to load |
| ld_bit | input | 1 | Value to load |
| uop_valid | input | 1 | Micro-operation valid |
| uop_code | input | 1 | 0 = clear, 1 = implication |
| uop_src | input | 4 | Source cell index |
| uop_dst | input | 4 | Target cell index |
| rd_idx | input | 4 | Cell to read |
| rd_bit | output | 1 | Registered read data |
| clash | output | 1 | Load and micro-operation hit the same cell on the previous edge |

## Verification
The assertions assume that every index presented is within the array, which always holds with the default sixteen cells and a 4-bit index. They also assume that control inputs are stable around the rising edge. The per-cell checks exclude the cycles in which a load targets the same cell, because the load takes precedence there. The stimulus changes every input only on the falling edge and uses only legal indices. Loads and micro-operations on the same cell are issued together only in the collision scenario.

// File: rtl/imply_pkg.sv
package imply_pkg;
  typedef enum logic {
    UOP_CLEAR = 1'b0,
    UOP_IMPLY = 1'b1
  } uop_e;

  function automatic logic imply_eval(input uop_e code, input logic src_v, input logic dst_v);
    return (code == UOP_IMPLY) ? (~src_v | dst_v) : 1'b0;
  endfunction
endpackage

// File: rtl/imply_step.sv
module imply_step
  import imply_pkg::*;
(
  input  uop_e code,
  input  logic src_v,
  input  logic dst_v,
  output logic res_v
);
  always_comb res_v = imply_eval(code, src_v, dst_v);
endmodule

// File: rtl/imply_cells.sv
module imply_cells
  import imply_pkg::*;
#(
  parameter int NCELLS = 16,
  localparam int IW = $clog2(NCELLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic          ld_bit,
  input  logic          uop_valid,
  input  uop_e          uop_code,
  input  logic [IW-1:0] uop_src,
  input  logic [IW-1:0] uop_dst,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_bit
);
  logic [NCELLS-1:0] cells;
  logic [NCELLS-1:0] cells_nxt;
  logic              src_v, dst_v, res_v;

  assign src_v = cells[uop_src];
  assign dst_v = cells[uop_dst];

  imply_step u_step (
    .code  (uop_code),
    .src_v (src_v),
    .dst_v (dst_v),
    .res_v (res_v)
  );

  for (genvar i = 0; i < NCELLS; i++) begin : g_cell
    logic ld_hit, op_hit;
    assign ld_hit = ld_en && (ld_idx == IW'(i));
    assign op_hit = uop_valid && (uop_dst == IW'(i));
    assign cells_nxt[i] = ld_hit ? ld_bit : (op_hit ? res_v : cells[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cells  <= '0;
      rd_bit <= 1'b0;
    end else begin
      cells  <= cells_nxt;
      rd_bit <= cells[rd_idx];
    end
  end

  // R1: implication result on target
  p_imply_result_r1: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_code == UOP_IMPLY && !(ld_en && ld_idx == uop_dst))
    |=> cells[$past(uop_dst)] == (~$past(src_v) | $past(dst_v)));

  // R2: source kept
  p_src_kept_r2: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_src != uop_dst && !(ld_en && ld_idx == uop_src))
    |=> cells[$past(uop_src)] == $past(src_v));

  // R3: clear forces zero
  p_clear_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_code == UOP_CLEAR && !(ld_en && ld_idx == uop_dst))
    |=> cells[$past(uop_dst)] == 1'b0);

  // R5: load takes effect and wins
  p_load_wins_r5: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> cells[$past(ld_idx)] == $past(ld_bit));

  // R7: registered read of old value
  p_read_old_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_bit == $past(cells[rd_idx]));

  // R8: reset clears
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (cells == '0 && rd_bit == 1'b0));

  // R9: idle keeps state
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!uop_valid && !ld_en) |=> $stable(cells));
endmodule

// File: rtl/imply_array_top.sv
module imply_array_top
  import imply_pkg::*;
#(
  parameter int NCELLS = 16,
  localparam int IW = $clog2(NCELLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [IW-1:0] ld_idx,
  input  logic          ld_bit,
  input  logic          uop_valid,
  input  logic          uop_code,
  input  logic [IW-1:0] uop_src,
  input  logic [IW-1:0] uop_dst,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_bit,
  output logic          clash
);
  uop_e code_e;
  logic same_cell;

  assign code_e    = uop_e'(uop_code);
  assign same_cell = ld_en && uop_valid && (ld_idx == uop_dst);

  imply_cells #(.NCELLS(NCELLS)) u_cells (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_en),
    .ld_idx    (ld_idx),
    .ld_bit    (ld_bit),
    .uop_valid (uop_valid),
    .uop_code  (code_e),
    .uop_src   (uop_src),
    .uop_dst   (uop_dst),
    .rd_idx    (rd_idx),
    .rd_bit    (rd_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) clash <= 1'b0;
    else     clash <= same_cell;
  end

  // R6: clash pulse follows a same-cell conflict
  p_clash_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_en && uop_valid && ld_idx == uop_dst) |=> clash);

  p_clash_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !(ld_en && uop_valid) |=> !clash);

  // R8: clash low after reset
  p_clash_reset_r8: assert property (@(posedge clk)
    rst |=> !clash);
endmodule

// File: tb/imply_array_top_test.sv
`timescale 1ns/1ps
module imply_array_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0, ld_bit = 1'b0;
  logic [3:0] ld_idx = '0;
  logic       uop_valid = 1'b0, uop_code = 1'b0;
  logic [3:0] uop_src = '0, uop_dst = '0, rd_idx = '0;
  logic       rd_bit, clash;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  imply_array_top uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_idx(ld_idx), .ld_bit(ld_bit),
    .uop_valid(uop_valid), .uop_code(uop_code), .uop_src(uop_src), .uop_dst(uop_dst),
    .rd_idx(rd_idx), .rd_bit(rd_bit), .clash(clash)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] idx, input logic v);
    @(negedge clk); ld_en = 1; ld_idx = idx; ld_bit = v;
    @(negedge clk); ld_en = 0;
  endtask

  task automatic uop(input logic code, input logic [3:0] s, input logic [3:0] d);
    @(negedge clk); uop_valid = 1; uop_code = code; uop_src = s; uop_dst = d;
    @(negedge clk); uop_valid = 0;
  endtask

  task automatic peek(input logic [3:0] idx, output logic v);
    @(negedge clk); rd_idx = idx;
    @(negedge clk); v = rd_bit;
  endtask

  task automatic t_reset;
    logic v;
    chk("R8 clash after reset", clash, 1'b0);
    for (int i = 0; i < 16; i++) begin
      peek(i[3:0], v);
      chk("R8 cell after reset", v, 1'b0);
    end
  endtask

  task automatic t_truth;
    logic v;
    for (int k = 0; k < 4; k++) begin
      load(4'd0, k[1]); load(4'd1, k[0]);
      uop(1'b1, 4'd0, 4'd1);
      peek(4'd1, v);
      chk("R1 implication", v, ~k[1] | k[0]);
      peek(4'd0, v);
      chk("R2 source kept", v, k[1]);
    end
  endtask

  task automatic t_clear;
    logic v;
    load(4'd7, 1'b1);
    uop(1'b0, 4'd3, 4'd7);
    peek(4'd7, v); chk("R3 clear", v, 1'b0);
    uop(1'b0, 4'd3, 4'd7);
    peek(4'd7, v); chk("R3 clear of zero", v, 1'b0);
  endtask

  task automatic t_self;
    logic v;
    load(4'd9, 1'b0);
    uop(1'b1, 4'd9, 4'd9);
    peek(4'd9, v); chk("R4 self implication", v, 1'b1);
  endtask

  task automatic t_collide;
    logic v;
    load(4'd4, 1'b1);
    @(negedge clk);
    ld_en = 1; ld_idx = 4'd4; ld_bit = 1'b1;
    uop_valid = 1; uop_code = 1'b0; uop_src = 4'd2; uop_dst = 4'd4;
    @(negedge clk);
    ld_en = 0; uop_valid = 0;
    chk("R6 clash raised", clash, 1'b1);
    @(negedge clk);
    chk("R6 clash drops", clash, 1'b0);
    peek(4'd4, v); chk("R5 load wins", v, 1'b1);
    load(4'd5, 1'b1);
    @(negedge clk);
    ld_en = 1; ld_idx = 4'd6; ld_bit = 1'b1;
    uop_valid = 1; uop_code = 1'b0; uop_src = 4'd2; uop_dst = 4'd5;
    @(negedge clk);
    ld_en = 0; uop_valid = 0;
    chk("R6 no clash on distinct cells", clash, 1'b0);
    peek(4'd6, v); chk("R6 load on other cell", v, 1'b1);
    peek(4'd5, v); chk("R6 clear on other cell", v, 1'b0);
  endtask

  task automatic t_read_latency;
    load(4'd11, 1'b0);
    @(negedge clk); rd_idx = 4'd11; ld_en = 1; ld_idx = 4'd11; ld_bit = 1'b1;
    @(negedge clk); ld_en = 0;
    chk("R7 old value on write edge", rd_bit, 1'b0);
    @(negedge clk);
    chk("R7 new value one cycle later", rd_bit, 1'b1);
  endtask

  task automatic t_idle;
    logic v;
    load(4'd12, 1'b1);
    @(negedge clk); uop_code = 1'b0; uop_dst = 4'd12; ld_idx = 4'd12; ld_bit = 1'b0;
    repeat (3) @(negedge clk);
    peek(4'd12, v); chk("R9 idle keeps cell", v, 1'b1);
  endtask

  task automatic t_nand;
    logic v;
    for (int k = 0; k < 4; k++) begin
      load(4'd13, k[1]); load(4'd14, k[0]);
      uop(1'b0, 4'd0, 4'd15);
      uop(1'b1, 4'd13, 4'd15);
      uop(1'b1, 4'd14, 4'd15);
      peek(4'd15, v);
      chk("R10 NAND sequence", v, ~(k[1] & k[0]));
    end
  endtask

  task automatic t_rst_again;
    logic v;
    load(4'd8, 1'b1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R8 read cleared", rd_bit, 1'b0);
    peek(4'd8, v); chk("R8 cell cleared", v, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_truth();
    t_clear();
    t_self();
    t_collide();
    t_read_latency();
    t_idle();
    t_nand();
    t_rst_again();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule